// File: doc/BRIEF.md
# Stack Primitive Operation Executor

This block carries out the short-form primitive operations of a dual-stack processor against its data stack of 32-bit cells. Each cycle it may accept one 5-bit operation code with a valid strobe. The two topmost cells sit in registers, and deeper cells go into a small spill array. The top cell is always visible at the output.

Besides arithmetic, logic, shuffles, small constant pushes and equality tests, the executor raises a one-cycle request asking the fetch logic to step over the next two instruction payloads. Return, byte memory access and unassigned codes are handled elsewhere in the core. For these codes the block only pulses a flag. Stack faults set sticky overflow and underflow flags, and the faulting operation leaves the stack unchanged.

Top module: `stack_prim_exec`

## Requirements
- R1: A synchronous active-high reset empties the stack and drives the top-of-stack output, the overflow, underflow, skip and unsupported outputs to zero.
- R2: Codes 24 to 31 push the constant equal to the code minus 24.
- R3: Code 0 adds the two topmost cells and code 1 subtracts the top cell from the cell beneath it. Both wrap modulo 2^32, pop two cells and push one result.
- R4: Code 2 increments the top cell and code 3 decrements it, both wrapping. Code 4 is bitwise AND and code 5 is bitwise OR of the two topmost cells, and both pop two cells and push one.
- R5: Code 7 duplicates the top cell, code 8 discards it and code 9 exchanges the two topmost cells.
- R6: Code 18 (not equal) and code 19 (equal) compare the two topmost cells, pop both, and push all-ones when the condition holds and zero when it does not.
- R7: Code 17 raises the skip output for exactly the one cycle after it is accepted and leaves the stack unchanged.
- R8: Codes 6, 10 to 16 and 20 to 23 raise the unsupported output for exactly the one cycle after acceptance and leave the stack unchanged.
- R9: An operation needing more cells than the stack holds sets a sticky underflow flag and leaves the stack unchanged. Only reset clears the flag.
- R10: A push onto a stack already holding DEPTH cells sets a sticky overflow flag and leaves the stack unchanged. Only reset clears the flag.
- R11: With the valid strobe low, the code input has no effect on the stack or on any output.
- R12: Cells pushed beyond the two registered cells return in last-in first-out order when the stack is popped down, across the full DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation code is valid this cycle |
| op_code | input | 5 | Primitive operation code |
| tos | output | 32 | Current top-of-stack cell |
| skip_req | output | 1 | Request to skip the next two payloads, one-cycle pulse |
| unsup | output | 1 | Unsupported code seen, one-cycle pulse |
| ovf | output | 1 | Sticky stack overflow flag |
| unf | output | 1 | Sticky stack underflow flag |

## Verification
Two events can meet in one cycle: a stack fault and an operation that would otherwise change the stack. One case is a constant push onto a full stack. Another is a binary operation or drop on a stack that is too shallow. The bench fills the stack to DEPTH and pushes once more, and it also drops and adds on an empty or single-cell stack. In each case it checks that the top-of-stack output keeps its previous value while the sticky flag rises and stays raised across later valid operations. A second collision occurs at the boundary between the registered cells and the spill array. There, a pop must refill the cell beneath the top from the spill array in the same cycle. The full fill and drain sequence judges this cell by cell against last-in first-out order.

// File: rtl/spx_pkg.sv
package spx_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_BIN, K_UNARY, K_DUP, K_DROP, K_SWAP, K_LIT, K_SKIP, K_BAD
  } op_kind_t;

  typedef enum logic [2:0] {
    A_ADD, A_SUB, A_INC, A_DEC, A_AND, A_OR, A_NE, A_EQ
  } alu_sel_t;

  typedef struct packed {
    op_kind_t  kind;
    alu_sel_t  alu;
    logic [1:0] need;   // cells required
    logic       grows;  // net push of one cell
    logic [2:0] lit;
  } op_dec_t;

endpackage

// File: rtl/spx_decode.sv
module spx_decode
  import spx_pkg::*;
(
  input  logic [4:0] code,
  output op_dec_t    dec
);
  always_comb begin
    dec = '{kind: K_BAD, alu: A_ADD, need: 2'd0, grows: 1'b0, lit: 3'd0};
    if (code[4:3] == 2'b11) begin
      dec.kind  = K_LIT;
      dec.grows = 1'b1;
      dec.lit   = code[2:0];
    end else begin
      case (code)
        5'd0:  begin dec.kind = K_BIN;   dec.alu = A_ADD; dec.need = 2'd2; end
        5'd1:  begin dec.kind = K_BIN;   dec.alu = A_SUB; dec.need = 2'd2; end
        5'd2:  begin dec.kind = K_UNARY; dec.alu = A_INC; dec.need = 2'd1; end
        5'd3:  begin dec.kind = K_UNARY; dec.alu = A_DEC; dec.need = 2'd1; end
        5'd4:  begin dec.kind = K_BIN;   dec.alu = A_AND; dec.need = 2'd2; end
        5'd5:  begin dec.kind = K_BIN;   dec.alu = A_OR;  dec.need = 2'd2; end
        5'd7:  begin dec.kind = K_DUP;   dec.need = 2'd1; dec.grows = 1'b1; end
        5'd8:  begin dec.kind = K_DROP;  dec.need = 2'd1; end
        5'd9:  begin dec.kind = K_SWAP;  dec.need = 2'd2; end
        5'd17: begin dec.kind = K_SKIP; end
        5'd18: begin dec.kind = K_BIN;   dec.alu = A_NE;  dec.need = 2'd2; end
        5'd19: begin dec.kind = K_BIN;   dec.alu = A_EQ;  dec.need = 2'd2; end
        default: dec.kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/spx_alu.sv
module spx_alu
  import spx_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_sel_t     sel,
  input  logic [W-1:0] under,  // cell beneath top
  input  logic [W-1:0] top,
  output logic [W-1:0] res
);
  always_comb begin
    case (sel)
      A_ADD:   res = under + top;
      A_SUB:   res = under - top;
      A_INC:   res = top + W'(1);
      A_DEC:   res = top - W'(1);
      A_AND:   res = under & top;
      A_OR:    res = under | top;
      A_NE:    res = (under != top) ? '1 : '0;
      default: res = (under == top) ? '1 : '0;
    endcase
  end
endmodule

// File: rtl/spx_spill.sv
module spx_spill #(
  parameter int W  = 32,
  parameter int N  = 14,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  // Distributed-RAM style: synchronous write, asynchronous read, no reset.
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/stack_prim_exec.sv
module stack_prim_exec
  import spx_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [4:0]   op_code,
  output logic [W-1:0] tos,
  output logic         skip_req,
  output logic         unsup,
  output logic         ovf,
  output logic         unf
);
  localparam int SPILL = DEPTH - 2;
  localparam int AW    = (SPILL > 1) ? $clog2(SPILL) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  op_dec_t       dec;
  logic [W-1:0]  nos, alu_res, sp_rd;
  logic [CW-1:0] cnt;

  logic [W-1:0]  n_tos, n_nos;
  logic [CW-1:0] n_cnt;
  logic          sp_we, n_skip, n_unsup, set_ovf, set_unf;
  logic          deep2, deep3;

  spx_decode u_dec (.code(op_code), .dec(dec));

  spx_alu #(.W(W)) u_alu (.sel(dec.alu), .under(nos), .top(tos), .res(alu_res));

  spx_spill #(.W(W), .N(SPILL), .AW(AW)) u_spill (
    .clk   (clk),
    .we    (sp_we),
    .waddr (AW'(cnt - CW'(2))),
    .wdata (nos),
    .raddr (AW'(cnt - CW'(3))),
    .rdata (sp_rd)
  );

  assign deep2 = (cnt >= CW'(2));
  assign deep3 = (cnt >= CW'(3));

  always_comb begin
    n_tos   = tos;
    n_nos   = nos;
    n_cnt   = cnt;
    sp_we   = 1'b0;
    n_skip  = 1'b0;
    n_unsup = 1'b0;
    set_ovf = 1'b0;
    set_unf = 1'b0;
    if (op_valid) begin
      if (cnt < CW'(dec.need)) begin
        set_unf = 1'b1;
      end else if (dec.grows && cnt == CW'(DEPTH)) begin
        set_ovf = 1'b1;
      end else begin
        case (dec.kind)
          K_BIN: begin
            n_tos = alu_res;
            n_nos = deep3 ? sp_rd : '0;
            n_cnt = cnt - CW'(1);
          end
          K_UNARY: n_tos = alu_res;
          K_DUP: begin
            n_nos = tos;
            sp_we = deep2;
            n_cnt = cnt + CW'(1);
          end
          K_LIT: begin
            n_tos = W'(dec.lit);
            n_nos = tos;
            sp_we = deep2;
            n_cnt = cnt + CW'(1);
          end
          K_DROP: begin
            n_tos = nos;
            n_nos = deep3 ? sp_rd : '0;
            n_cnt = cnt - CW'(1);
          end
          K_SWAP: begin
            n_tos = nos;
            n_nos = tos;
          end
          K_SKIP:  n_skip  = 1'b1;
          K_BAD:   n_unsup = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos      <= '0;
      nos      <= '0;
      cnt      <= '0;
      skip_req <= 1'b0;
      unsup    <= 1'b0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      tos      <= n_tos;
      nos      <= n_nos;
      cnt      <= n_cnt;
      skip_req <= n_skip;
      unsup    <= n_unsup;
      ovf      <= ovf | set_ovf;
      unf      <= unf | set_unf;
    end
  end

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R10
  AST_FAULT_KEEPS_TOS: assert property (@(posedge clk) disable iff (rst)
    ($rose(unf) || $rose(ovf)) |-> $stable(tos)); // R9
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R10
  AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> ($past(op_valid) && $past(op_code) == 5'd17)); // R7
  AST_SKIP_KEEPS_TOS: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> $stable(tos)); // R7
  AST_UNSUP_KEEPS_TOS: assert property (@(posedge clk) disable iff (rst)
    unsup |-> $stable(tos)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(tos) && !skip_req && !unsup)); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(skip_req && unsup)); // R8
endmodule

// File: tb/sim_stack_prim_exec.sv
`timescale 1ns/1ps
module sim_stack_prim_exec;
  localparam int DEPTH = 16;
  localparam int NV    = 27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = 5'd0;
  logic [31:0] tos;
  logic        skip_req, unsup, ovf, unf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stack_prim_exec #(.W(32), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .tos(tos), .skip_req(skip_req), .unsup(unsup), .ovf(ovf), .unf(unf)
  );

  // {code, expected tos, expected skip, expected unsup}
  localparam logic [38:0] VEC [NV] = '{
    {5'd27, 32'd3,          1'b0, 1'b0},  // R2
    {5'd29, 32'd5,          1'b0, 1'b0},  // R2
    {5'd0,  32'd8,          1'b0, 1'b0},  // R3 add
    {5'd31, 32'd7,          1'b0, 1'b0},  // R2
    {5'd1,  32'd1,          1'b0, 1'b0},  // R3 8-7
    {5'd2,  32'd2,          1'b0, 1'b0},  // R4 inc
    {5'd3,  32'd1,          1'b0, 1'b0},  // R4 dec
    {5'd3,  32'd0,          1'b0, 1'b0},  // R4
    {5'd3,  32'hFFFFFFFF,   1'b0, 1'b0},  // R4 wrap
    {5'd26, 32'd2,          1'b0, 1'b0},  // R2
    {5'd4,  32'd2,          1'b0, 1'b0},  // R4 and
    {5'd29, 32'd5,          1'b0, 1'b0},  // R2
    {5'd5,  32'd7,          1'b0, 1'b0},  // R4 or
    {5'd7,  32'd7,          1'b0, 1'b0},  // R5 dup
    {5'd19, 32'hFFFFFFFF,   1'b0, 1'b0},  // R6 eq true
    {5'd25, 32'd1,          1'b0, 1'b0},  // R2
    {5'd18, 32'hFFFFFFFF,   1'b0, 1'b0},  // R6 ne true
    {5'd24, 32'd0,          1'b0, 1'b0},  // R2
    {5'd9,  32'hFFFFFFFF,   1'b0, 1'b0},  // R5 swap
    {5'd8,  32'd0,          1'b0, 1'b0},  // R5 drop
    {5'd17, 32'd0,          1'b1, 1'b0},  // R7 skip
    {5'd6,  32'd0,          1'b0, 1'b1},  // R8
    {5'd10, 32'd0,          1'b0, 1'b1},  // R8
    {5'd20, 32'd0,          1'b0, 1'b1},  // R8
    {5'd28, 32'd4,          1'b0, 1'b0},  // R2
    {5'd19, 32'd0,          1'b0, 1'b0},  // R6 eq false
    {5'd8,  32'd0,          1'b0, 1'b0}   // R5 drop to empty
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] c);
    op_code  = c;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1", "tos", tos, 32'd0);
    chk("R1", "flags", {28'd0, skip_req, unsup, ovf, unf}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][38:34]);
      chk("R2-6 vec", "tos", tos, VEC[i][33:2]);
      chk("R7/R8 vec", "pulses", {30'd0, skip_req, unsup}, {30'd0, VEC[i][1], VEC[i][0]});
      chk("R9/R10 vec", "faults", {30'd0, ovf, unf}, 32'd0);
    end

    // R7: skip pulse lasts one cycle
    do_op(5'd17);
    chk("R7", "skip on", {31'd0, skip_req}, 32'd1);
    @(negedge clk);
    chk("R7", "skip off", {31'd0, skip_req}, 32'd0);

    // R11: invalid strobe leaves everything
    do_op(5'd30);
    op_code = 5'd26;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "tos", tos, 32'd6);
    op_code = 5'd6;
    @(negedge clk);
    chk("R11", "unsup", {31'd0, unsup}, 32'd0);

    // R9: underflow on add with one cell, then on drops
    do_op(5'd0);
    chk("R9", "unf", {31'd0, unf}, 32'd1);
    chk("R9", "tos kept", tos, 32'd6);
    do_op(5'd8);
    chk("R9", "tos after drop", tos, 32'd0);
    do_op(5'd8);
    chk("R9", "empty tos", tos, 32'd0);
    do_op(5'd27);
    chk("R9", "sticky", {31'd0, unf}, 32'd1);
    chk("R9", "push works", tos, 32'd3);

    // R1: reset clears sticky flag
    do_reset();
    chk("R1", "unf cleared", {31'd0, unf}, 32'd0);
    chk("R1", "tos cleared", tos, 32'd0);

    // R10/R12: fill to DEPTH, overflow, drain in LIFO order
    for (int i = 0; i < DEPTH; i++) do_op(5'(24 + (i % 8)));
    chk("R12", "full tos", tos, 32'((DEPTH - 1) % 8));
    do_op(5'd25);
    chk("R10", "ovf", {31'd0, ovf}, 32'd1);
    chk("R10", "tos kept", tos, 32'((DEPTH - 1) % 8));
    do_op(5'd7);
    chk("R10", "dup on full kept", tos, 32'((DEPTH - 1) % 8));
    for (int j = 1; j < DEPTH; j++) begin
      do_op(5'd8);
      chk("R12", "lifo", tos, 32'((DEPTH - 1 - j) % 8));
    end
    chk("R10", "ovf sticky", {31'd0, ovf}, 32'd1);
    chk("R12", "no unf", {31'd0, unf}, 32'd0);

    // R12: spilled values take part in arithmetic
    do_reset();
    for (int i = 0; i < 6; i++) do_op(5'(25 + i));
    for (int i = 0; i < 5; i++) do_op(5'd0);
    chk("R12", "sum 1..6", tos, 32'd21);
    chk("R3", "sub order", tos - 32'd0, 32'd21);
    do_op(5'd31);
    do_op(5'd1);
    chk("R3", "21-7", tos, 32'd14);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule